// File: doc/BRIEF.md
# Triggered Dual-Channel Sample Logger

This block sits between a two-channel converter and a large sample store. While a capture runs, it takes one sample from each channel on every clock, sign-extends each to a half word, packs the pair into one full-width word and issues one memory write per cycle on a write-stream port. The write addresses are consecutive and start at zero.

Several loggers share one sampling clock and one trigger wire. The trigger is synchronised inside each logger, and capture begins on its rising edge, so every instance starts on the same clock. A capture ends in one of two ways. Either the programmed word limit has been written, or the trigger drops first. The number of words actually written is then held on an output.

Once the logger reports done, a host reads the stored words back at its own pace through a request port. The logger forwards a request to the store only when capture is finished and the address lies inside the logged range. Any other request is refused and flagged.

Top module: `sample_logger`

## Requirements
- R1: The trigger passes a two-stage synchroniser, and capture begins on its rising edge. If trigIn is first sampled high at clock edge k, captureBusy rises after edge k+2 and the first write strobe appears after edge k+3.
- R2: Each written word holds channel A sign-extended to 16 bits in bits [15:0] and channel B sign-extended to 16 bits in bits [31:16]. Both samples are the ones present at the edge that issues the write.
- R3: During capture, exactly one word is written per clock. The write addresses start at 0 and increase by one per word.
- R4: After the write that brings the count to the word limit, captureDone is set on the same edge and no further write follows.
- R5: If the synchronised trigger is low while capturing, capture ends with no write in that cycle. wordCount then equals the number of words written.
- R6: A rising trigger with a word limit of 0 moves straight to done with wordCount 0 and no write.
- R7: A new rising trigger edge after done starts a fresh capture whose first address is 0.
- R8: A read request is refused while capturing or before any capture has finished. A refused request raises rdError for one cycle on the next edge and issues no memory read.
- R9: When done, a request whose address is below wordCount is forwarded on the next edge. memRdEn is high for one cycle and memRdAddr equals the requested address.
- R10: When done, a request whose address is at or above wordCount is refused with rdError. memRdEn and rdError are never high together.
- R11: While reset is held, wrEn, memRdEn, rdError, captureBusy and captureDone are low and wordCount is 0.
- R12: captureBusy and captureDone are never high at the same time.
- R13: A word limit above the address space (2^ADDR_W) is treated as 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | 1 | Shared asynchronous capture trigger |
| chanA | input | SAMPLE_W | Channel A sample, two's complement |
| chanB | input | SAMPLE_W | Channel B sample, two's complement |
| limitWords | input | ADDR_W+1 | Number of words to capture |
| wrEn | output | 1 | Write strobe to the store |
| wrAddr | output | ADDR_W | Write word address |
| wrData | output | 2*HALF_W | Packed sample pair |
| captureBusy | output | 1 | Capture in progress |
| captureDone | output | 1 | Capture finished, readback allowed |
| wordCount | output | ADDR_W+1 | Words written by the last capture |
| rdReq | input | 1 | Host readback request |
| rdAddr | input | ADDR_W | Host readback word address |
| memRdEn | output | 1 | Forwarded read strobe to the store |
| memRdAddr | output | ADDR_W | Forwarded read address |
| rdError | output | 1 | One-cycle pulse for a refused request |

## Verification
The bench builds the logger with ADDR_W = 6, which gives a 64-word address space. A limit of 100 therefore reaches the clamp and fills the whole space to its last address within a few hundred cycles. The 14/16-bit sample and half-word widths stay at their defaults, so both the sign-extension bits and the channel halves are exercised with negative and positive samples. At this size every capture ending is covered: the limit, the trigger falling early, a zero limit and a restart after done.

// File: rtl/logger_pkg.sv
package logger_pkg;

  typedef enum logic [1:0] {
    LOG_IDLE    = 2'd0,
    LOG_CAPTURE = 2'd1,
    LOG_DONE    = 2'd2
  } logState_t;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic clearCount;
    logic writeWord;
    logic rdGrant;
    logic rdRefuse;
  } ctrlStrobe_t;

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
      end
    end else begin : gMulti
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/logger_ctrl.sv
module logger_ctrl
  import logger_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigSync,
  input  logic        limitZero,
  input  logic        lastWord,
  input  logic        rdReq,
  input  logic        rdInRange,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done
);

  logState_t state, nextState;
  logic trigPrev;
  logic trigRise;

  assign trigRise = trigSync & ~trigPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= LOG_IDLE;
      trigPrev <= 1'b0;
    end else begin
      state    <= nextState;
      trigPrev <= trigSync;
    end
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      LOG_CAPTURE: begin
        if (!trigSync) begin
          nextState = LOG_DONE;
        end else begin
          strobe.writeWord = 1'b1;
          if (lastWord) nextState = LOG_DONE;
        end
      end
      default: begin
        if (trigRise) begin
          strobe.clearCount = 1'b1;
          nextState = limitZero ? LOG_DONE : LOG_CAPTURE;
        end
      end
    endcase

    if (rdReq) begin
      if (state == LOG_DONE && rdInRange) strobe.rdGrant  = 1'b1;
      else                                strobe.rdRefuse = 1'b1;
    end
  end

  assign busy = (state == LOG_CAPTURE);
  assign done = (state == LOG_DONE);

endmodule

// File: rtl/logger_datapath.sv
module logger_datapath
  import logger_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int HALF_W   = 16,
  parameter int ADDR_W   = 28
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [SAMPLE_W-1:0]   chanA,
  input  logic [SAMPLE_W-1:0]   chanB,
  input  logic [ADDR_W:0]       limitWords,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic                  wrEn,
  output logic [ADDR_W-1:0]     wrAddr,
  output logic [2*HALF_W-1:0]   wrData,
  output logic [ADDR_W:0]       wordCount,
  output logic                  memRdEn,
  output logic [ADDR_W-1:0]     memRdAddr,
  output logic                  rdError,
  output logic                  lastWord,
  output logic                  limitZero,
  output logic                  rdInRange
);

  localparam int CNT_W = ADDR_W + 1;
  localparam int EXT_W = HALF_W - SAMPLE_W;
  localparam logic [CNT_W-1:0] DEPTH = CNT_W'(1) << ADDR_W;

  logic [CNT_W-1:0]    count;
  logic [CNT_W-1:0]    effLimit;
  logic [HALF_W-1:0]   extA, extB;

  assign effLimit  = (limitWords > DEPTH) ? DEPTH : limitWords;
  assign lastWord  = (count + CNT_W'(1)) == effLimit;
  assign limitZero = (effLimit == '0);
  assign rdInRange = ({1'b0, rdAddr} < count);

  generate
    if (EXT_W > 0) begin : gExtend
      assign extA = {{EXT_W{chanA[SAMPLE_W-1]}}, chanA};
      assign extB = {{EXT_W{chanB[SAMPLE_W-1]}}, chanB};
    end else begin : gDirect
      assign extA = chanA;
      assign extB = chanB;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      wrEn      <= 1'b0;
      wrAddr    <= '0;
      wrData    <= '0;
      memRdEn   <= 1'b0;
      memRdAddr <= '0;
      rdError   <= 1'b0;
    end else begin
      wrEn    <= strobe.writeWord;
      memRdEn <= strobe.rdGrant;
      rdError <= strobe.rdRefuse;
      if (strobe.clearCount) begin
        count <= '0;
      end else if (strobe.writeWord) begin
        count  <= count + CNT_W'(1);
        wrAddr <= count[ADDR_W-1:0];
        wrData <= {extB, extA};
      end
      if (strobe.rdGrant) memRdAddr <= rdAddr;
    end
  end

  assign wordCount = count;

endmodule

// File: rtl/sample_logger.sv
module sample_logger
  import logger_pkg::*;
#(
  parameter int SAMPLE_W    = 14,
  parameter int HALF_W      = 16,
  parameter int ADDR_W      = 28,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  trigIn,
  input  logic [SAMPLE_W-1:0]   chanA,
  input  logic [SAMPLE_W-1:0]   chanB,
  input  logic [ADDR_W:0]       limitWords,
  output logic                  wrEn,
  output logic [ADDR_W-1:0]     wrAddr,
  output logic [2*HALF_W-1:0]   wrData,
  output logic                  captureBusy,
  output logic                  captureDone,
  output logic [ADDR_W:0]       wordCount,
  input  logic                  rdReq,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic                  memRdEn,
  output logic [ADDR_W-1:0]     memRdAddr,
  output logic                  rdError
);

  ctrlStrobe_t strobe;
  logic trigSync, lastWord, limitZero, rdInRange;

  trig_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(trigIn), .syncOut(trigSync)
  );

  logger_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .trigSync(trigSync), .limitZero(limitZero),
    .lastWord(lastWord), .rdReq(rdReq), .rdInRange(rdInRange),
    .strobe(strobe), .busy(captureBusy), .done(captureDone)
  );

  logger_datapath #(.SAMPLE_W(SAMPLE_W), .HALF_W(HALF_W), .ADDR_W(ADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .chanA(chanA), .chanB(chanB),
    .limitWords(limitWords), .rdAddr(rdAddr), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .wordCount(wordCount), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .rdError(rdError), .lastWord(lastWord),
    .limitZero(limitZero), .rdInRange(rdInRange)
  );

endmodule

// File: rtl/logger_checker.sv
module logger_checker #(
  parameter int SAMPLE_W = 14,
  parameter int HALF_W   = 16,
  parameter int ADDR_W   = 28
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W:0]     limitWords,
  input logic                wrEn,
  input logic [ADDR_W-1:0]   wrAddr,
  input logic [2*HALF_W-1:0] wrData,
  input logic                captureBusy,
  input logic                captureDone,
  input logic                memRdEn,
  input logic                rdError
);

  AST_WR_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $past(captureBusy)); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && $past(wrEn)) |-> (wrAddr == ADDR_W'($past(wrAddr) + 1'b1))); // R3

  AST_ADDR_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ({1'b0, wrAddr} < limitWords)); // R4

  AST_SIGN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ((&wrData[HALF_W-1:SAMPLE_W-1]) || !(|wrData[HALF_W-1:SAMPLE_W-1]))); // R2

  AST_SIGN_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ((&wrData[2*HALF_W-1:HALF_W+SAMPLE_W-1]) ||
              !(|wrData[2*HALF_W-1:HALF_W+SAMPLE_W-1]))); // R2

  AST_STATE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({captureBusy, captureDone})); // R12

  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> $past(captureDone)); // R8

  AST_RD_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && rdError)); // R10

endmodule

bind sample_logger logger_checker #(.SAMPLE_W(SAMPLE_W), .HALF_W(HALF_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .limitWords(limitWords), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .captureBusy(captureBusy), .captureDone(captureDone),
  .memRdEn(memRdEn), .rdError(rdError)
);

// File: tb/sample_logger_test.sv
module sample_logger_test;

  localparam int SW = 14;
  localparam int HW = 16;
  localparam int AW = 6;
  localparam int CW = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigIn = 1'b0;
  logic [SW-1:0] chanA = '0;
  logic [SW-1:0] chanB = '0;
  logic [CW-1:0] limitWords = '0;
  logic rdReq = 1'b0;
  logic [AW-1:0] rdAddr = '0;

  logic wrEn, captureBusy, captureDone, memRdEn, rdError;
  logic [AW-1:0] wrAddr, memRdAddr;
  logic [2*HW-1:0] wrData;
  logic [CW-1:0] wordCount;

  int nChecks = 0;
  int nBad = 0;
  int cycles = 0;
  int wrSeen = 0;
  int sampleSeed = 1;

  sample_logger #(.SAMPLE_W(SW), .HALF_W(HW), .ADDR_W(AW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .chanA(chanA), .chanB(chanB),
    .limitWords(limitWords), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .captureBusy(captureBusy), .captureDone(captureDone), .wordCount(wordCount),
    .rdReq(rdReq), .rdAddr(rdAddr), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .rdError(rdError)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int  mMode = 0;       // 0 idle, 1 capturing, 2 done
  bit  q1 = 0, q2 = 0, qp = 0;
  int  mCnt = 0;
  bit  eWrEn = 0, eRdEn = 0, eRdErr = 0;
  int  eWrAddr = 0, eRdAddr = 0;
  logic [31:0] eWrData = '0;

  function automatic logic [31:0] packPair(input logic [SW-1:0] a, input logic [SW-1:0] b);
    int ia, ib;
    ia = int'($signed(a));
    ib = int'($signed(b));
    return {ib[15:0], ia[15:0]};
  endfunction

  always @(posedge clk) begin : refModel
    bit rise, hi;
    int lim;
    if (!rstN) begin
      mMode = 0; q1 = 0; q2 = 0; qp = 0; mCnt = 0;
      eWrEn = 0; eRdEn = 0; eRdErr = 0; eWrAddr = 0; eRdAddr = 0; eWrData = '0;
    end else begin
      rise = q2 && !qp;
      hi   = q2;
      lim  = (int'(limitWords) > DEPTH) ? DEPTH : int'(limitWords);
      eWrEn = 0; eRdEn = 0; eRdErr = 0;
      if (rdReq) begin
        if (mMode == 2 && int'(rdAddr) < mCnt) begin
          eRdEn = 1; eRdAddr = int'(rdAddr);
        end else begin
          eRdErr = 1;
        end
      end
      if (mMode == 1) begin
        if (!hi) mMode = 2;
        else begin
          eWrEn = 1; eWrAddr = mCnt; eWrData = packPair(chanA, chanB);
          mCnt++;
          if (mCnt == lim) mMode = 2;
        end
      end else if (rise) begin
        mCnt = 0;
        mMode = (lim == 0) ? 2 : 1;
      end
      qp = q2; q2 = q1; q1 = trigIn;
    end
  end

  // compare every cycle, away from the active edge; new samples each cycle
  always @(negedge clk) begin
    if (rstN) begin
      check("R1 busy", captureBusy, mMode == 1);
      check("R4 done", captureDone, mMode == 2);
      check("R5 wordCount", wordCount, mCnt);
      check("R3 wrEn", wrEn, eWrEn);
      if (eWrEn) begin
        check("R3 wrAddr", wrAddr, eWrAddr);
        check("R2 wrData", wrData, eWrData);
      end
      check("R9 memRdEn", memRdEn, eRdEn);
      if (eRdEn) check("R9 memRdAddr", memRdAddr, eRdAddr);
      check("R8 rdError", rdError, eRdErr);
      check("R12 exclusive", captureBusy && captureDone, 1'b0);
      if (wrEn) wrSeen++;
    end
    sampleSeed = sampleSeed * 1103515245 + 12345;
    chanA = sampleSeed[SW+2:3];
    chanB = sampleSeed[SW+16:17];
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nBad++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  task automatic readOne(input int addr);
    @(negedge clk);
    rdReq = 1'b1; rdAddr = AW'(addr);
    @(negedge clk);
    rdReq = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 wrEn", wrEn, 0);
    check("R11 memRdEn", memRdEn, 0);
    check("R11 rdError", rdError, 0);
    check("R11 busy", captureBusy, 0);
    check("R11 done", captureDone, 0);
    check("R11 wordCount", wordCount, 0);
    rstN = 1'b1;

    // read before any capture is refused
    readOne(0);
    check("R8 idle refuse", {memRdEn, rdError}, 2'b01);

    // limit stop, with a read during capture
    limitWords = CW'(5);
    @(negedge clk); trigIn = 1'b1;
    repeat (4) @(negedge clk);
    rdReq = 1'b1; rdAddr = '0;
    @(negedge clk); rdReq = 1'b0;
    check("R8 capture refuse", {memRdEn, rdError}, 2'b01);
    repeat (15) @(negedge clk);
    trigIn = 1'b0;
    repeat (5) @(negedge clk);
    check("R4 limit count", wordCount, 5);
    check("R4 limit done", captureDone, 1);
    readOne(0);
    check("R9 grant addr0", {memRdEn, memRdAddr}, {1'b1, AW'(0)});
    readOne(4);
    check("R9 grant addr4", {memRdEn, memRdAddr}, {1'b1, AW'(4)});
    readOne(5);
    check("R10 out of range", {memRdEn, rdError}, 2'b01);

    // limit above the address space is clamped
    limitWords = CW'(100);
    @(negedge clk); trigIn = 1'b1;
    repeat (90) @(negedge clk);
    trigIn = 1'b0;
    repeat (5) @(negedge clk);
    check("R13 clamp count", wordCount, DEPTH);
    readOne(DEPTH - 1);
    check("R9 last addr", {memRdEn, memRdAddr}, {1'b1, AW'(DEPTH - 1)});

    // early trigger drop, restart from done, start timing
    limitWords = CW'(40);
    @(negedge clk); trigIn = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 not yet busy", captureBusy, 0);
    @(negedge clk);
    check("R1 busy after sync", captureBusy, 1);
    check("R1 no write yet", wrEn, 0);
    @(negedge clk);
    check("R1 first write", wrEn, 1);
    check("R7 restart addr", wrAddr, 0);
    repeat (8) @(negedge clk);
    trigIn = 1'b0;
    repeat (6) @(negedge clk);
    check("R5 early stop count", wordCount, 11);
    check("R5 early stop done", captureDone, 1);
    readOne(10);
    check("R9 last early word", {memRdEn, memRdAddr}, {1'b1, AW'(10)});
    readOne(11);
    check("R10 beyond early count", {memRdEn, rdError}, 2'b01);

    // zero limit
    limitWords = '0;
    wrSeen = 0;
    @(negedge clk); trigIn = 1'b1;
    repeat (10) @(negedge clk);
    trigIn = 1'b0;
    repeat (4) @(negedge clk);
    check("R6 zero done", captureDone, 1);
    check("R6 zero count", wordCount, 0);
    check("R6 zero writes", wrSeen, 0);
    readOne(0);
    check("R6 zero read refuse", {memRdEn, rdError}, 2'b01);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule